// File: doc/BRIEF.md
# Nested Stream Index Counter

This block follows a stream of data words that carry a valid flag, and tracks where each valid word sits in a nested set of index dimensions. Typical dimensions, from fastest to slowest, are time word, channel, beam, sequence, and a combined beam-and-subband index. Each dimension is a counter with its own start value, exclusive stop value and step. A dimension moves on only when the dimension just below it has reached its last value and is wrapping back to its start.

The block passes the stream through one register stage. Each delayed word comes out with the counts that describe it, a first-word flag and a last-word flag for every dimension, and packet framing. The framing is start-of-packet and end-of-packet, taken from the fastest dimension. The block also builds a 32-bit tag word from the current indices, to be used by a later header stage. It keeps a copy of an incoming 64-bit block sequence number, refreshed at every boundary of the outermost dimension.

There is no back-pressure. The block has no ready input and never stalls. Every input word with valid set is accepted and appears on the output exactly one cycle later. Idle cycles (valid low) pass through as idle cycles.

Top module: `nidx_stream_counter`

## Requirements
- R1: The output stream is the input stream delayed by exactly one clock. `out_valid` equals the previous cycle's `in_valid`. On a valid output, `out_data` equals the data of the word accepted one cycle earlier.
- R2: Dimension k counts from its start value, adding its step each time it advances, and returns to its start after the last value that is below its exclusive stop. Dimension 0 advances on every valid word and on no idle cycle.
- R3: Dimension k+1 advances only on a valid word where dimension k is at its last value, and therefore wrapping. At all other times it holds.
- R4: Bit k of `out_first` is set on a valid output word where dimensions 0..k are all at their start values. Bit k of `out_last` is set where dimensions 0..k are all at their last values. Both vectors are zero when `out_valid` is low.
- R5: `out_sop` marks the first word of dimension 0 and `out_eop` marks its last word. Every packet therefore holds exactly as many valid words as dimension 0 has values. After an `out_eop`, the next valid word carries `out_sop`.
- R6: `out_tag` is laid out as follows (bit 0 is the least significant bit):
  - bits 31..20 are zero;
  - bits 19..16 hold the low 4 bits of the dimension 2 (beam) count;
  - bits 15..13 hold the compound-beam index, which is the dimension 4 count divided by SB_PER_CB (low 3 bits);
  - bits 12..8 hold the subband, which is the dimension 4 count modulo SB_PER_CB (low 5 bits);
  - bits 7..6 hold the low 2 bits of the dimension 1 (channel) count;
  - bits 5..0 hold the low 6 bits of the dimension 3 (sequence) count.
- R7: `bsn_q` takes the `bsn_in` value presented with the first valid word after reset. It also takes the `bsn_in` value presented with every word that is the last word of the outermost dimension. It changes only in the cycle where that word appears on the output, and holds otherwise.
- R8: While `rst` is high at a clock edge, `out_valid`, `out_first`, `out_last`, `out_sop`, `out_eop` and `bsn_q` are cleared and all counters return to their start values. The first valid word after reset has every bit of `out_first` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word qualifier |
| in_data | input | DATA_W | Input word |
| bsn_in | input | BSN_W | Running block sequence number |
| out_valid | output | 1 | Delayed word qualifier |
| out_data | output | DATA_W | Delayed word |
| out_sop | output | 1 | First word of a packet |
| out_eop | output | 1 | Last word of a packet |
| out_cnt | output | NUM_DIMS*CNT_W | Count of each dimension, dimension k in bits k*CNT_W upward |
| out_first | output | NUM_DIMS | Per-dimension first-word flags |
| out_last | output | NUM_DIMS | Per-dimension last-word flags |
| out_tag | output | 32 | Packed index tag |
| bsn_q | output | BSN_W | Captured block sequence number |

## Verification
The bench runs the stream through two full outermost wraps and beyond. The idle gaps between words are irregular, so a counter that stepped on idle cycles would drift from the mixed-radix reference. One dimension uses a start of 1 and a step of 2, which catches a counter that assumes a zero start or a unit step, or that compares the stop value inclusively. Each packet's length is measured between its start and end flags, so a fastest dimension that wrapped one word early or late shows up as a wrong packet length. The sequence-number input changes on every cycle, including idle cycles. The bench applies a reset in the middle of a packet: a latch that captured on idle cycles, missed the first word after reset, or lost the outermost boundary would show a wrong value, and so would a counter that did not return to its start.

// File: rtl/nidx_pkg.sv
`timescale 1ns/1ps
package nidx_pkg;
  // Tag word field positions; a downstream header stage decodes these.
  localparam int TAG_W        = 32;
  localparam int TAG_SEQ_W    = 6;
  localparam int TAG_CH_W     = 2;
  localparam int TAG_SB_W     = 5;
  localparam int TAG_CB_W     = 3;
  localparam int TAG_BEAM_W   = 4;
  localparam int TAG_USED_W   = TAG_SEQ_W + TAG_CH_W + TAG_SB_W + TAG_CB_W + TAG_BEAM_W;
  localparam int TAG_PAD_W    = TAG_W - TAG_USED_W;
  localparam int MAX_DIMS     = 10;
endpackage

// File: rtl/nidx_dim_counter.sv
`timescale 1ns/1ps
module nidx_dim_counter #(
  parameter int CNT_W = 16,
  parameter int START = 0,
  parameter int STOP  = 4,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_valid,
  input  logic             below_first,
  input  logic             below_last,
  output logic [CNT_W-1:0] cnt,
  output logic             chain_first,
  output logic             chain_last
);
  localparam logic [CNT_W:0]   STEP_X  = (CNT_W+1)'(STEP);
  localparam logic [CNT_W:0]   STOP_X  = (CNT_W+1)'(STOP);
  localparam logic [CNT_W-1:0] START_V = CNT_W'(START);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   step_sum;
  logic             at_first;
  logic             at_last;
  logic             advance;

  assign step_sum = {1'b0, cnt_q} + STEP_X;
  assign at_first = (cnt_q == START_V);
  assign at_last  = (step_sum >= STOP_X);
  // this dimension moves only when every faster one is wrapping
  assign advance  = word_valid & below_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= START_V;
    end else if (advance) begin
      cnt_q <= at_last ? START_V : step_sum[CNT_W-1:0];
    end
  end

  assign cnt         = cnt_q;
  assign chain_first = below_first & at_first;
  assign chain_last  = below_last & at_last;
endmodule

// File: rtl/nidx_tag_pack.sv
`timescale 1ns/1ps
module nidx_tag_pack
  import nidx_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int SB_PER_CB = 24
) (
  input  logic [CNT_W-1:0] ch_cnt,
  input  logic [CNT_W-1:0] beam_cnt,
  input  logic [CNT_W-1:0] seq_cnt,
  input  logic [CNT_W-1:0] cbsb_cnt,
  output logic [TAG_W-1:0] tag
);
  localparam logic [CNT_W-1:0] SB_DIV = CNT_W'(SB_PER_CB);

  logic [TAG_CB_W-1:0]   cb_idx;
  logic [TAG_SB_W-1:0]   sb_idx;
  logic [TAG_BEAM_W-1:0] beam_idx;
  logic [TAG_CH_W-1:0]   ch_idx;
  logic [TAG_SEQ_W-1:0]  seq_idx;

  assign cb_idx   = TAG_CB_W'(cbsb_cnt / SB_DIV);
  assign sb_idx   = TAG_SB_W'(cbsb_cnt % SB_DIV);
  assign beam_idx = TAG_BEAM_W'(beam_cnt);
  assign ch_idx   = TAG_CH_W'(ch_cnt);
  assign seq_idx  = TAG_SEQ_W'(seq_cnt);

  // local channel = subband joined above the channel index
  assign tag = {{TAG_PAD_W{1'b0}}, beam_idx, cb_idx, sb_idx, ch_idx, seq_idx};
endmodule

// File: rtl/nidx_bsn_latch.sv
`timescale 1ns/1ps
module nidx_bsn_latch #(
  parameter int BSN_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             word_valid,
  input  logic             outer_end,
  input  logic [BSN_W-1:0] bsn_in,
  output logic [BSN_W-1:0] bsn_q
);
  logic pending_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q <= 1'b1;
      bsn_q     <= '0;
    end else if (word_valid) begin
      pending_q <= 1'b0;
      if (pending_q || outer_end) begin
        bsn_q <= bsn_in;
      end
    end
  end
endmodule

// File: rtl/nidx_stream_counter.sv
`timescale 1ns/1ps
module nidx_stream_counter
  import nidx_pkg::*;
#(
  parameter int NUM_DIMS  = 5,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 16,
  parameter int BSN_W     = 64,
  parameter int SB_PER_CB = 24,
  parameter int DIM_START [NUM_DIMS] = '{0, 0, 0, 0, 0},
  parameter int DIM_STOP  [NUM_DIMS] = '{2000, 4, 12, 4, 88},
  parameter int DIM_STEP  [NUM_DIMS] = '{1, 1, 1, 1, 1}
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [DATA_W-1:0]         in_data,
  input  logic [BSN_W-1:0]          bsn_in,
  output logic                      out_valid,
  output logic [DATA_W-1:0]         out_data,
  output logic                      out_sop,
  output logic                      out_eop,
  output logic [NUM_DIMS*CNT_W-1:0] out_cnt,
  output logic [NUM_DIMS-1:0]       out_first,
  output logic [NUM_DIMS-1:0]       out_last,
  output logic [TAG_W-1:0]          out_tag,
  output logic [BSN_W-1:0]          bsn_q
);
  localparam int CNT_BUS_W = NUM_DIMS * CNT_W;

  logic [CNT_W-1:0]     cnt_w   [NUM_DIMS];
  logic [NUM_DIMS-1:0]  first_w;
  logic [NUM_DIMS-1:0]  last_w;
  logic [NUM_DIMS:0]    up_first;
  logic [NUM_DIMS:0]    up_last;
  logic [CNT_BUS_W-1:0] cnt_bus;
  logic [TAG_W-1:0]     tag_w;

  assign up_first[0] = 1'b1;
  assign up_last[0]  = 1'b1;

  for (genvar k = 0; k < NUM_DIMS; k++) begin : g_dim
    nidx_dim_counter #(
      .CNT_W (CNT_W),
      .START (DIM_START[k]),
      .STOP  (DIM_STOP[k]),
      .STEP  (DIM_STEP[k])
    ) u_cnt (
      .clk         (clk),
      .rst         (rst),
      .word_valid  (in_valid),
      .below_first (up_first[k]),
      .below_last  (up_last[k]),
      .cnt         (cnt_w[k]),
      .chain_first (first_w[k]),
      .chain_last  (last_w[k])
    );
    assign up_first[k+1]              = first_w[k];
    assign up_last[k+1]               = last_w[k];
    assign cnt_bus[k*CNT_W +: CNT_W]  = cnt_w[k];
  end

  if (NUM_DIMS >= 5) begin : g_tag
    nidx_tag_pack #(
      .CNT_W     (CNT_W),
      .SB_PER_CB (SB_PER_CB)
    ) u_tag (
      .ch_cnt   (cnt_w[1]),
      .beam_cnt (cnt_w[2]),
      .seq_cnt  (cnt_w[3]),
      .cbsb_cnt (cnt_w[4]),
      .tag      (tag_w)
    );
  end else begin : g_no_tag
    assign tag_w = '0;
  end

  nidx_bsn_latch #(
    .BSN_W (BSN_W)
  ) u_bsn (
    .clk        (clk),
    .rst        (rst),
    .word_valid (in_valid),
    .outer_end  (last_w[NUM_DIMS-1]),
    .bsn_in     (bsn_in),
    .bsn_q      (bsn_q)
  );

  // single output stage: data and its descriptors move together
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_cnt   <= '0;
      out_first <= '0;
      out_last  <= '0;
      out_tag   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= in_data;
        out_cnt   <= cnt_bus;
        out_first <= first_w;
        out_last  <= last_w;
        out_tag   <= tag_w;
      end else begin
        out_first <= '0;
        out_last  <= '0;
      end
    end
  end

  assign out_sop = out_first[0];
  assign out_eop = out_last[0];
endmodule

// File: rtl/nidx_stream_counter_chk.sv
`timescale 1ns/1ps
module nidx_stream_counter_chk #(
  parameter int NUM_DIMS = 5,
  parameter int CNT_W    = 16,
  parameter int BSN_W    = 64,
  parameter int DIM_START [NUM_DIMS] = '{0, 0, 0, 0, 0},
  parameter int DIM_STOP  [NUM_DIMS] = '{2000, 4, 12, 4, 88}
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      out_valid,
  input logic                      out_sop,
  input logic                      out_eop,
  input logic [NUM_DIMS*CNT_W-1:0] out_cnt,
  input logic [NUM_DIMS-1:0]       out_first,
  input logic [NUM_DIMS-1:0]       out_last,
  input logic [BSN_W-1:0]          bsn_q
);
  logic prev_eop_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_eop_q <= 1'b1;
    end else if (out_valid) begin
      prev_eop_q <= out_eop;
    end
  end

  // R1
  delay_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(in_valid)));

  // R4
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ((|out_first) || (|out_last)) |-> out_valid);

  // R5
  sop_follows_eop_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_sop == prev_eop_q));

  // R7
  bsn_moves_on_word_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(bsn_q)) |-> out_valid);

  for (genvar k = 0; k < NUM_DIMS; k++) begin : g_dim_chk
    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ((int'(out_cnt[k*CNT_W +: CNT_W]) >= DIM_START[k]) &&
                     (int'(out_cnt[k*CNT_W +: CNT_W]) <  DIM_STOP[k])));
    if (k > 0) begin : g_nest
      // R4
      first_nested_chk: assert property (@(posedge clk) disable iff (rst)
        out_first[k] |-> out_first[k-1]);
      // R4
      last_nested_chk: assert property (@(posedge clk) disable iff (rst)
        out_last[k] |-> out_last[k-1]);
    end
  end
endmodule

bind nidx_stream_counter nidx_stream_counter_chk #(
  .NUM_DIMS  (NUM_DIMS),
  .CNT_W     (CNT_W),
  .BSN_W     (BSN_W),
  .DIM_START (DIM_START),
  .DIM_STOP  (DIM_STOP)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .out_cnt   (out_cnt),
  .out_first (out_first),
  .out_last  (out_last),
  .bsn_q     (bsn_q)
);

// File: tb/nidx_stream_counter_test.sv
`timescale 1ns/1ps
module nidx_stream_counter_test;
  localparam int ND     = 5;
  localparam int DW     = 32;
  localparam int CW     = 16;
  localparam int BW     = 64;
  localparam int SBC    = 2;
  localparam int B_START [ND] = '{0, 1, 0, 0, 0};
  localparam int B_STOP  [ND] = '{4, 5, 3, 2, 3};
  localparam int B_STEP  [ND] = '{1, 2, 1, 1, 1};
  // words per outermost wrap = 4*2*3*2*3 = 144
  localparam int WRAP_WORDS = 144;
  // idle cycles inserted before each word, walked cyclically
  localparam int GAP_TAB [16] = '{0, 0, 1, 0, 3, 0, 0, 2, 0, 1, 0, 0, 5, 0, 1, 0};

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [DW-1:0]   in_data = '0;
  logic [BW-1:0]   bsn_in = '0;
  logic            out_valid, out_sop, out_eop;
  logic [DW-1:0]   out_data;
  logic [ND*CW-1:0] out_cnt;
  logic [ND-1:0]   out_first, out_last;
  logic [31:0]     out_tag;
  logic [BW-1:0]   bsn_q;

  always #10 clk = ~clk;

  nidx_stream_counter #(
    .NUM_DIMS (ND), .DATA_W (DW), .CNT_W (CW), .BSN_W (BW), .SB_PER_CB (SBC),
    .DIM_START (B_START), .DIM_STOP (B_STOP), .DIM_STEP (B_STEP)
  ) uut (
    .clk (clk), .rst (rst), .in_valid (in_valid), .in_data (in_data),
    .bsn_in (bsn_in), .out_valid (out_valid), .out_data (out_data),
    .out_sop (out_sop), .out_eop (out_eop), .out_cnt (out_cnt),
    .out_first (out_first), .out_last (out_last), .out_tag (out_tag),
    .bsn_q (bsn_q)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  int dig [ND];
  int cyc      = 0;
  int word_no  = 0;
  int pkt_len  = 0;
  bit pend     = 1'b1;
  logic [BW-1:0] exp_bsn = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int nvals(input int k);
    return (B_STOP[k] - B_START[k] + B_STEP[k] - 1) / B_STEP[k];
  endfunction

  function automatic int val(input int k);
    return B_START[k] + dig[k] * B_STEP[k];
  endfunction

  task automatic model_reset();
    for (int k = 0; k < ND; k++) dig[k] = 0;
    pend    = 1'b1;
    exp_bsn = '0;
    pkt_len = 0;
  endtask

  task automatic idle_cycle();
    in_valid = 1'b0;
    bsn_in   = 64'hEE00_0000_0000_0000 + 64'(cyc);
    @(posedge clk); @(negedge clk);
    // R1 idle passes as idle; R4 flags cleared
    check(out_valid == 1'b0, "R1 idle", 64'(out_valid), 0);
    check(out_first == '0 && out_last == '0, "R4 idle flags",
          64'({out_first, out_last}), 0);
  endtask

  task automatic send_word(input int gap);
    logic [ND-1:0] ef, el;
    logic [ND*CW-1:0] ec;
    logic [31:0] et;
    logic [BW-1:0] b;
    bit all0, allL;
    for (int g = 0; g < gap; g++) idle_cycle();
    all0 = 1'b1; allL = 1'b1;
    for (int k = 0; k < ND; k++) begin
      all0 = all0 && (dig[k] == 0);
      allL = allL && (dig[k] == nvals(k) - 1);
      ef[k] = all0;
      el[k] = allL;
      ec[k*CW +: CW] = CW'(val(k));
    end
    et = {12'd0, 4'(val(2)), 3'(val(4) / SBC), 5'(val(4) % SBC), 2'(val(1)), 6'(val(3))};
    b  = 64'hB500_0000_0000_0000 + 64'(word_no) * 7;
    if (pend || el[ND-1]) exp_bsn = b;
    pend = 1'b0;
    in_valid = 1'b1;
    in_data  = 32'hD000_0000 + 32'(word_no);
    bsn_in   = b;
    @(posedge clk); @(negedge clk);
    check(out_valid && out_data == 32'hD000_0000 + 32'(word_no), "R1 data",
          64'(out_data), 64'(32'hD000_0000 + 32'(word_no)));
    // R2 and R3: counts follow the mixed-radix reference
    check(out_cnt == ec, "R2/R3 counts", 64'(out_cnt), 64'(ec));
    check(out_first == ef, "R4 first", 64'(out_first), 64'(ef));
    check(out_last == el, "R4 last", 64'(out_last), 64'(el));
    check(out_sop == ef[0] && out_eop == el[0], "R5 framing",
          64'({out_sop, out_eop}), 64'({ef[0], el[0]}));
    check(out_tag == et, "R6 tag", 64'(out_tag), 64'(et));
    check(bsn_q == exp_bsn, "R7 bsn", bsn_q, exp_bsn);
    if (out_sop) pkt_len = 1; else pkt_len++;
    if (out_eop) check(pkt_len == B_STOP[0], "R5 packet length", 64'(pkt_len),
                       64'(B_STOP[0]));
    word_no++;
    for (int k = 0; k < ND; k++) begin
      if (dig[k] == nvals(k) - 1) dig[k] = 0;
      else begin dig[k]++; break; end
    end
  endtask

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    // R8 reset state
    check(out_valid == 0 && out_first == 0 && out_last == 0 && bsn_q == 0,
          "R8 reset state", 64'({out_valid, out_first, out_last}), 0);
    rst = 1'b0;
    // table walk: two full outer wraps plus a few words
    for (int i = 0; i < 2 * WRAP_WORDS + 9; i++) begin
      send_word(GAP_TAB[i % 16] + ((i >= WRAP_WORDS) ? int'($urandom_range(0, 1)) : 0));
    end
    // directed: reset in the middle of a packet with valid high
    in_valid = 1'b1;
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check(out_valid == 0 && out_first == 0 && out_last == 0, "R8 flags in reset",
          64'({out_valid, out_first, out_last}), 0);
    check(bsn_q == 0, "R8 bsn cleared", bsn_q, 0);
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    in_valid = 1'b0;
    model_reset();
    send_word(2);
    check(out_first == '1, "R8 first word all-first", 64'(out_first), 64'({ND{1'b1}}));
    // back-to-back words after reset
    for (int i = 0; i < 40; i++) send_word(0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end
endmodule